// File: doc/BRIEF.md
# Firmware Memory Window Decoder

This block sits behind a low-pin-count host bus parser. It receives memory cycles that have already been parsed, one at a time, and decides whether each cycle is forwarded to a local 2 MB flash expansion bus. Two kinds of cycle can arrive: firmware-hub memory cycles and plain bus memory cycles. Only one kind is honoured at a time. The accepted kind is chosen by a firmware-select strap, and a memory-enable strap gates all forwarding. Both straps are captured while reset is held. A configuration bit can override the captured firmware-select value. When ID qualification is enabled, a firmware-hub cycle must also carry a matching ID.

Two system windows are mapped onto the single device:

- The 128 KB legacy window is placed in the top 128 KB of the device.
- The 16 MB top-of-memory window folds onto the device every 2 MB.

An accepted cycle drives chip select 0, the local address and a read or write strobe. These outputs stay held until the host side reports the cycle done.

Cycles enter over a valid/ready handshake, and a cycle is taken on a rising edge where both are high. Ready is low while a forwarded access is held on the local bus. The source must keep its cycle steady while ready is low, and the block ignores it during that time. A rejected cycle never stalls the input: ready stays high. Configuration inputs are plain level signals, sampled when a cycle is taken.

Top module: `fwmem_window_dec`

## Requirements
- R1: While the captured memory-enable strap is 0, no cycle is forwarded (fwd_accept 0, lb_cs0_n 1), whatever the firmware-select strap and the override bits say.
- R2: Both straps are captured on every clock edge while rst_n is low. Strap changes after reset is released have no effect until the next reset.
- R3: With memory enable captured as 1, the effective firmware-select value picks the cycle kind. A value of 1 accepts only cycles with cyc_fwh=1 (firmware-hub). A value of 0 accepts only cycles with cyc_fwh=0 (plain memory).
- R4: When cfg_ovr_en is 1, cfg_ovr_val replaces the captured firmware-select strap as the effective value.
- R5: When cfg_idq_en is 1, a firmware-hub cycle is accepted only if cyc_id equals cfg_idq_val. Plain memory cycles are not affected by ID qualification.
- R6: Addresses 000E0000h to 000FFFFFh are forwarded with lb_addr[19:0] = cyc_addr[19:0] and lb_addr[20] = 1.
- R7: Addresses FF000000h to FFFFFFFFh are forwarded with lb_addr[20:0] = cyc_addr[20:0]. Address bits 23:21 are not checked, so all eight 2 MB sub-windows reach the same device locations.
- R8: Any address outside both windows is rejected.
- R9: Only single-byte transfers are accepted, encoded as cyc_size = 2'b00. Any other size is rejected.
- R10: The outputs change on the rising edge that takes a cycle. For an accepted cycle, from the next cycle onward: fwd_accept is 1, lb_cs0_n is 0, lb_addr holds the mapped address, and exactly one of lb_rd_n / lb_wr_n is 0 (lb_wr_n when cyc_write=1). All of these hold until the edge where cyc_done is sampled high. After that edge, lb_cs0_n, lb_rd_n and lb_wr_n are 1 and fwd_accept is 0.
- R11: cyc_ready is 0 while a forwarded access is held. A cycle presented during that time is ignored and does not change any output.
- R12: During and after reset: lb_cs0_n, lb_rd_n and lb_wr_n are 1, fwd_accept is 0 and cyc_ready is 1.
- R13: A rejected cycle gives fwd_accept 0 on the next cycle, with no chip select or strobe activity and cyc_ready still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset; straps are captured while low |
| strap_memen | input | 1 | Memory-enable strap |
| strap_fwsel | input | 1 | Firmware-select strap (1 = firmware-hub cycles) |
| cfg_ovr_en | input | 1 | Use cfg_ovr_val instead of the captured firmware-select strap |
| cfg_ovr_val | input | 1 | Override value for firmware select |
| cfg_idq_en | input | 1 | Enable ID qualification of firmware-hub cycles |
| cfg_idq_val | input | 4 | ID that firmware-hub cycles must carry when qualification is on |
| cyc_valid | input | 1 | Parsed memory cycle present |
| cyc_ready | output | 1 | Block can take a cycle |
| cyc_fwh | input | 1 | Cycle kind: 1 firmware-hub, 0 plain memory |
| cyc_addr | input | 32 | System memory address |
| cyc_write | input | 1 | 1 write, 0 read |
| cyc_size | input | 2 | Transfer size code, 00 = one byte |
| cyc_id | input | 4 | Firmware-hub ID field of the cycle |
| cyc_done | input | 1 | Host side finished the forwarded access |
| fwd_accept | output | 1 | Last taken cycle was forwarded; cleared at release |
| lb_addr | output | 21 | Local bus address |
| lb_cs0_n | output | 1 | Active-low chip select 0 |
| lb_rd_n | output | 1 | Active-low read strobe |
| lb_wr_n | output | 1 | Active-low write strobe |

## Verification
A wrong captured strap or override path shows up one cycle after the next taken cycle. fwd_accept then has the wrong value for a whole class of cycle kinds, so every cycle of the affected kind fails at once. A wrong window decode or address mapping appears on lb_addr and lb_cs0_n on the cycle after the take. Boundary addresses and aliased sub-windows make a single wrong bit visible. A hold register that drifts, or that fails to release, shows during the hold: lb_addr changes, or lb_cs0_n stays low, on the cycle after cyc_done. A stray cycle presented during the hold makes corruption of the held state visible at the same cycle boundary.

// File: rtl/fwmem_pkg.sv
package fwmem_pkg;

  typedef enum logic [1:0] {
    WIN_NONE   = 2'd0,
    WIN_LEGACY = 2'd1,
    WIN_TOP    = 2'd2
  } win_e;

  localparam int unsigned SIZE_W    = 2;
  localparam logic [1:0]  SIZE_BYTE = 2'b00;

endpackage

// File: rtl/fwmem_strap_latch.sv
module fwmem_strap_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_memen,
  input  logic strap_fwsel,
  output logic memen_q,
  output logic fwsel_q
);
  // captures continuously while reset is held; frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      memen_q <= strap_memen;
      fwsel_q <= strap_fwsel;
    end
  end
endmodule

// File: rtl/fwmem_window_map.sv
module fwmem_window_map
  import fwmem_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned LB_W          = 21,
  parameter logic [31:0] LEG_BASE      = 32'h000E_0000,
  parameter int unsigned LEG_SPAN_LOG2 = 17,
  parameter int unsigned TOP_TAG_W     = 8,
  parameter bit          LEG_AT_TOP    = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic [LB_W-1:0]   map_addr
);
  localparam int unsigned LEG_TAG_W = ADDR_W - LEG_SPAN_LOG2;
  localparam logic [ADDR_W-1:0] LEG_TAG_FULL = ADDR_W'(LEG_BASE >> LEG_SPAN_LOG2);
  localparam logic [LEG_TAG_W-1:0] LEG_TAG = LEG_TAG_FULL[LEG_TAG_W-1:0];

  logic            leg_hit;
  logic            top_hit;
  logic [LB_W-1:0] leg_addr;

  assign leg_hit = (addr[ADDR_W-1:LEG_SPAN_LOG2] == LEG_TAG);
  assign top_hit = &addr[ADDR_W-1 -: TOP_TAG_W];

  generate
    if (LEG_AT_TOP) begin : g_leg_top
      assign leg_addr = {1'b1, addr[LB_W-2:0]};
    end else begin : g_leg_flat
      assign leg_addr = addr[LB_W-1:0];
    end
  endgenerate

  always_comb begin
    win      = WIN_NONE;
    map_addr = '0;
    if (leg_hit) begin
      win      = WIN_LEGACY;
      map_addr = leg_addr;
    end else if (top_hit) begin
      win      = WIN_TOP;
      map_addr = addr[LB_W-1:0];
    end
  end
endmodule

// File: rtl/fwmem_accept_ctl.sv
module fwmem_accept_ctl
  import fwmem_pkg::*;
#(
  parameter int unsigned ID_W = 4
) (
  input  logic              memen_q,
  input  logic              fwsel_q,
  input  logic              cfg_ovr_en,
  input  logic              cfg_ovr_val,
  input  logic              cfg_idq_en,
  input  logic [ID_W-1:0]   cfg_idq_val,
  input  logic              cyc_fwh,
  input  logic [SIZE_W-1:0] cyc_size,
  input  logic [ID_W-1:0]   cyc_id,
  input  win_e              win,
  output logic              accept
);
  logic fw_mode;
  logic kind_ok;
  logic id_ok;
  logic size_ok;
  logic win_ok;

  assign fw_mode = cfg_ovr_en ? cfg_ovr_val : fwsel_q;
  assign kind_ok = memen_q && (cyc_fwh == fw_mode);
  assign id_ok   = !(cfg_idq_en && cyc_fwh) || (cyc_id == cfg_idq_val);
  assign size_ok = (cyc_size == SIZE_BYTE);
  assign win_ok  = (win != WIN_NONE);
  assign accept  = kind_ok && id_ok && size_ok && win_ok;
endmodule

// File: rtl/fwmem_lbus_hold.sv
module fwmem_lbus_hold #(
  parameter int unsigned LB_W = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            accept,
  input  logic            write,
  input  logic [LB_W-1:0] map_addr,
  input  logic            done,
  output logic            busy,
  output logic            fwd_accept,
  output logic [LB_W-1:0] lb_addr,
  output logic            lb_cs0_n,
  output logic            lb_rd_n,
  output logic            lb_wr_n
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      fwd_accept <= 1'b0;
      lb_addr    <= '0;
      lb_cs0_n   <= 1'b1;
      lb_rd_n    <= 1'b1;
      lb_wr_n    <= 1'b1;
    end else if (take) begin
      fwd_accept <= accept;
      busy       <= accept;
      if (accept) begin
        lb_addr  <= map_addr;
        lb_cs0_n <= 1'b0;
        lb_rd_n  <= write;
        lb_wr_n  <= !write;
      end
    end else if (busy && done) begin
      busy       <= 1'b0;
      fwd_accept <= 1'b0;
      lb_addr    <= '0;
      lb_cs0_n   <= 1'b1;
      lb_rd_n    <= 1'b1;
      lb_wr_n    <= 1'b1;
    end
  end

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_cs0_n && !done) |=> (!lb_cs0_n && $stable(lb_addr) && $stable(lb_rd_n)));
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_cs0_n && done) |=> (lb_cs0_n && lb_rd_n && lb_wr_n && !fwd_accept));
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_cs0_n |-> $countones({lb_rd_n, lb_wr_n}) == 1);
  p_busy_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_cs0_n |-> busy);
endmodule

// File: rtl/fwmem_window_dec.sv
module fwmem_window_dec
  import fwmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LB_W   = 21,
  parameter int unsigned ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_memen,
  input  logic              strap_fwsel,
  input  logic              cfg_ovr_en,
  input  logic              cfg_ovr_val,
  input  logic              cfg_idq_en,
  input  logic [ID_W-1:0]   cfg_idq_val,
  input  logic              cyc_valid,
  output logic              cyc_ready,
  input  logic              cyc_fwh,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              cyc_write,
  input  logic [1:0]        cyc_size,
  input  logic [ID_W-1:0]   cyc_id,
  input  logic              cyc_done,
  output logic              fwd_accept,
  output logic [LB_W-1:0]   lb_addr,
  output logic              lb_cs0_n,
  output logic              lb_rd_n,
  output logic              lb_wr_n
);
  logic            memen_q;
  logic            fwsel_q;
  win_e            win;
  logic [LB_W-1:0] map_addr;
  logic            accept;
  logic            busy;
  logic            take;

  assign cyc_ready = !busy;
  assign take      = cyc_valid && cyc_ready;

  fwmem_strap_latch u_straps (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_memen (strap_memen),
    .strap_fwsel (strap_fwsel),
    .memen_q     (memen_q),
    .fwsel_q     (fwsel_q)
  );

  fwmem_window_map #(
    .ADDR_W (ADDR_W),
    .LB_W   (LB_W)
  ) u_map (
    .addr     (cyc_addr),
    .win      (win),
    .map_addr (map_addr)
  );

  fwmem_accept_ctl #(
    .ID_W (ID_W)
  ) u_ctl (
    .memen_q     (memen_q),
    .fwsel_q     (fwsel_q),
    .cfg_ovr_en  (cfg_ovr_en),
    .cfg_ovr_val (cfg_ovr_val),
    .cfg_idq_en  (cfg_idq_en),
    .cfg_idq_val (cfg_idq_val),
    .cyc_fwh     (cyc_fwh),
    .cyc_size    (cyc_size),
    .cyc_id      (cyc_id),
    .win         (win),
    .accept      (accept)
  );

  fwmem_lbus_hold #(
    .LB_W (LB_W)
  ) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .accept     (accept),
    .write      (cyc_write),
    .map_addr   (map_addr),
    .done       (cyc_done),
    .busy       (busy),
    .fwd_accept (fwd_accept),
    .lb_addr    (lb_addr),
    .lb_cs0_n   (lb_cs0_n),
    .lb_rd_n    (lb_rd_n),
    .lb_wr_n    (lb_wr_n)
  );

  p_no_mem_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !memen_q) |=> (!fwd_accept && lb_cs0_n));
  p_legacy_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && accept && win == WIN_LEGACY) |=> lb_addr[LB_W-1]);
  p_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && win == WIN_NONE) |=> (lb_cs0_n && !fwd_accept));
  p_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cyc_size != SIZE_BYTE) |=> !fwd_accept);
  p_reject_ready_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !accept) |=> cyc_ready);
endmodule

// File: tb/tb_fwmem_window_dec.sv
`timescale 1ns/1ps
module tb_fwmem_window_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_memen = 1'b0, strap_fwsel = 1'b0;
  logic        cfg_ovr_en = 1'b0, cfg_ovr_val = 1'b0, cfg_idq_en = 1'b0;
  logic [3:0]  cfg_idq_val = 4'h0;
  logic        cyc_valid = 1'b0, cyc_fwh = 1'b0, cyc_write = 1'b0, cyc_done = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic [1:0]  cyc_size = '0;
  logic [3:0]  cyc_id = '0;
  logic        cyc_ready, fwd_accept, lb_cs0_n, lb_rd_n, lb_wr_n;
  logic [20:0] lb_addr;

  int checks = 0;
  int errors = 0;
  logic m_memen, m_fwsel;

  always #2 clk = ~clk;

  fwmem_window_dec dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_acc(logic fwh, logic [31:0] a, logic [1:0] sz, logic [3:0] id);
    logic mode;
    logic inwin;
    mode  = cfg_ovr_en ? cfg_ovr_val : m_fwsel;
    inwin = (a >= 32'h000E_0000 && a <= 32'h000F_FFFF) || (a >= 32'hFF00_0000);
    if (!m_memen || fwh != mode || sz != 2'b00 || !inwin) return 1'b0;
    if (cfg_idq_en && fwh && id != cfg_idq_val) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [20:0] exp_addr(logic [31:0] a);
    if (a < 32'h0010_0000) return {1'b1, a[19:0]};
    return a[20:0];
  endfunction

  task automatic do_reset(logic me, logic fs);
    @(negedge clk);
    rst_n = 1'b0; strap_memen = me; strap_fwsel = fs;
    m_memen = me; m_fwsel = fs;
    repeat (3) @(negedge clk);
    chk("R12 cs", lb_cs0_n, 1); chk("R12 acc", fwd_accept, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 ready", cyc_ready, 1);
    chk("R12 strobes", {lb_rd_n, lb_wr_n}, 2'b11);
    strap_memen = ~me; strap_fwsel = ~fs; // R2: ignored until next reset
  endtask

  task automatic do_cyc(string req, logic fwh, logic [31:0] a, logic wr, logic [1:0] sz, logic [3:0] id);
    logic e;
    logic [20:0] ea;
    e  = exp_acc(fwh, a, sz, id);
    ea = exp_addr(a);
    chk({req, " ready"}, cyc_ready, 1);
    cyc_valid = 1'b1; cyc_fwh = fwh; cyc_addr = a; cyc_write = wr; cyc_size = sz; cyc_id = id;
    @(negedge clk);
    cyc_valid = 1'b0;
    chk({req, " accept"}, fwd_accept, e);
    chk({req, " cs"}, lb_cs0_n, !e);
    if (e) begin
      chk({req, " addr"}, lb_addr, ea);
      chk({req, " strobes R10"}, {lb_rd_n, lb_wr_n}, {wr, !wr});
      for (int k = 0; k < int'($urandom_range(0, 2)); k++) begin
        cyc_valid = 1'b1; cyc_addr = ~a; cyc_write = !wr; cyc_fwh = fwh;
        @(negedge clk);
        chk("R11 ready low", cyc_ready, 0);
        chk("R11 addr held", lb_addr, ea);
        chk("R11 strobe held", lb_wr_n, !wr);
      end
      cyc_valid = 1'b0; cyc_done = 1'b1;
      @(negedge clk);
      cyc_done = 1'b0;
      chk("R10 release cs", lb_cs0_n, 1);
      chk("R10 release acc", fwd_accept, 0);
      chk("R10 release strobes", {lb_rd_n, lb_wr_n}, 2'b11);
      chk("R10 ready back", cyc_ready, 1);
    end else begin
      chk("R13 strobes idle", {lb_rd_n, lb_wr_n}, 2'b11);
      chk("R13 ready", cyc_ready, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(1'b1, 1'b1);
    // R2: straps flipped after reset, firmware-hub still accepted
    do_cyc("R2 fwh", 1'b1, 32'hFFFF_0010, 1'b0, 2'b00, 4'h0);
    do_cyc("R6 low edge", 1'b1, 32'h000E_0000, 1'b0, 2'b00, 4'h0);
    do_cyc("R6 high edge", 1'b1, 32'h000F_FFFF, 1'b1, 2'b00, 4'h0);
    do_cyc("R8 below legacy", 1'b1, 32'h000D_FFFF, 1'b0, 2'b00, 4'h0);
    do_cyc("R8 above legacy", 1'b1, 32'h0010_0000, 1'b0, 2'b00, 4'h0);
    do_cyc("R8 below top", 1'b1, 32'hFEFF_FFFF, 1'b0, 2'b00, 4'h0);
    do_cyc("R7 base", 1'b1, 32'hFF00_0000, 1'b1, 2'b00, 4'h0);
    do_cyc("R7 alias a", 1'b1, 32'hFF3A_BCDE, 1'b0, 2'b00, 4'h0);
    do_cyc("R7 alias b", 1'b1, 32'hFFFA_BCDE, 1'b0, 2'b00, 4'h0);
    do_cyc("R9 word", 1'b1, 32'hFFE0_0004, 1'b0, 2'b01, 4'h0);
    do_cyc("R3 plain rejected", 1'b0, 32'hFFE0_0004, 1'b0, 2'b00, 4'h0);
    cfg_idq_en = 1'b1; cfg_idq_val = 4'h5;
    do_cyc("R5 id match", 1'b1, 32'hFFF0_0000, 1'b0, 2'b00, 4'h5);
    do_cyc("R5 id miss", 1'b1, 32'hFFF0_0000, 1'b0, 2'b00, 4'h6);
    cfg_ovr_en = 1'b1; cfg_ovr_val = 1'b0;
    do_cyc("R4 plain via override", 1'b0, 32'hFFF0_0100, 1'b1, 2'b00, 4'h9);
    do_cyc("R4 fwh via override", 1'b1, 32'hFFF0_0100, 1'b0, 2'b00, 4'h5);
    do_reset(1'b0, 1'b1);
    do_cyc("R1 fwh", 1'b1, 32'hFFF0_0000, 1'b0, 2'b00, 4'h5);
    do_cyc("R1 plain", 1'b0, 32'h000E_1234, 1'b0, 2'b00, 4'h5);
    cfg_ovr_en = 1'b0; cfg_idq_en = 1'b0;
    do_cyc("R1 no override", 1'b1, 32'h000E_1234, 1'b0, 2'b00, 4'h0);
    do_reset(1'b1, 1'b0);
    do_cyc("R3 plain", 1'b0, 32'h000E_1234, 1'b1, 2'b00, 4'h0);
    do_cyc("R3 fwh rejected", 1'b1, 32'h000E_1234, 1'b1, 2'b00, 4'h0);
    for (int n = 0; n < 800; n++) begin
      logic [31:0] a;
      int sel;
      if (n % 200 == 199) do_reset(1'($urandom), 1'($urandom));
      sel = int'($urandom_range(0, 3));
      a = $urandom;
      if (sel == 0) a = 32'h000E_0000 | (a & 32'h0001_FFFF);
      else if (sel == 1) a = a | 32'hFF00_0000;
      cfg_ovr_en = ($urandom_range(0, 3) == 0);
      cfg_ovr_val = 1'($urandom);
      cfg_idq_en = 1'($urandom);
      cfg_idq_val = 4'($urandom_range(0, 3));
      do_cyc("R3 R6 R7 random", 1'($urandom), a, 1'($urandom),
             ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b00, 4'($urandom_range(0, 3)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule